// File: doc/BRIEF.md
# Four-Stage Pseudo-Random Sequence Generator

This block is a clocked four-bit linear feedback shift register that walks through a fixed cycle of fifteen non-zero patterns. Each enabled step moves every stage one place down the chain. The first stage takes the exclusive-OR of the two last stages. A parallel port can place any pattern into the register, including the all-zero pattern. When the register holds all zeros, the next enabled step puts it back on the seed, so it cannot lock up.

The four stage values are visible at the outputs. A serial bit shows the stage that is about to leave the chain. A one-cycle marker rises each time the register completes a full period and returns to the seed by normal stepping. Typical uses are test pattern generation and dithering logic that needs a short repeatable pseudo-random stream.

Top module: `lfsr4_gen`

## Requirements
- R1: When `rst` is high at a rising clock edge, the register becomes the seed X1..X4 = 1000 and `wrap_pulse` becomes 0. `rst` is synchronous.
- R2: On a step (`step_en` high, `load_en` low, state non-zero), the stages update as follows: X2 takes the old X1, X3 takes the old X2, X4 takes the old X3, and X1 takes old X3 XOR old X4.
- R3: Starting from the seed, 15 successive steps show the states 0100, 0010, 1001, 1100, 0110, 1011, 0101, 1010, 1101, 1110, 1111, 0111, 0011, 0001, and then 1000 again. No state repeats within the period.
- R4: With `step_en` and `load_en` both low, the stages and `wrap_pulse` keep their values, except that `wrap_pulse` returns to 0.
- R5: With `load_en` high, the next state is `load_val`, where bit 3 is X1 and bit 0 is X4. This happens whatever the value of `step_en`.
- R6: If the state is 0000 and a step occurs, the next state is the seed 1000.
- R7: `wrap_pulse` is high for exactly one cycle, in the cycle after a step from 0001 to 1000. It stays low after loads, after recovery from 0000, and after reset.
- R8: `serial_out` always equals X4.
- R9: Priority is `rst` over `load_en`, and `load_en` over `step_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| step_en | input | 1 | Advance the sequence by one state |
| load_en | input | 1 | Load `load_val` into the stages |
| load_val | input | 4 | Parallel pattern, bit 3 = X1 ... bit 0 = X4 |
| x1 | output | 1 | Stage 1 value |
| x2 | output | 1 | Stage 2 value |
| x3 | output | 1 | Stage 3 value |
| x4 | output | 1 | Stage 4 value |
| serial_out | output | 1 | Bit about to shift out (stage 4) |
| wrap_pulse | output | 1 | Marks return to seed by a normal step |

## Verification
The assertions assume that `rst`, `step_en`, `load_en` and `load_val` are known (not X) at every clock edge. They also assume that reset is asserted at the first edge. The checks that compare against past inputs rely on `load_val` being stable around the edge. The bench drives every input only on falling edges from a seeded `$urandom` stream, so these conditions always hold. The bench loads all-zero and near-wrap patterns on purpose, so the recovery and wrap paths run often rather than only by chance.

// File: rtl/lfsr4_pkg.sv
package lfsr4_pkg;
    localparam int STAGES    = 4;
    localparam int TAP_HI    = 1;          // bit index of X3
    localparam int TAP_LO    = 0;          // bit index of X4
    localparam int PERIOD    = (1 << STAGES) - 1;

    typedef logic [STAGES-1:0] stage_vec_t;

    localparam stage_vec_t SEED_VAL = stage_vec_t'(1) << (STAGES - 1);
    localparam stage_vec_t LAST_VAL = stage_vec_t'(1);
    localparam stage_vec_t ZERO_VAL = '0;

    typedef struct packed {
        stage_vec_t stages;
        logic       wrap;
    } lfsr_reg_t;
endpackage

// File: rtl/lfsr4_step.sv
module lfsr4_step
    import lfsr4_pkg::*;
(
    input  stage_vec_t cur_stages,
    output stage_vec_t nxt_stages,
    output logic       from_zero
);
    logic feedback;
    stage_vec_t shifted;

    assign feedback  = cur_stages[TAP_HI] ^ cur_stages[TAP_LO];
    assign from_zero = (cur_stages == ZERO_VAL);

    // stage k (lower index) takes stage k+1 (nearer X1)
    for (genvar k = 0; k < STAGES - 1; k++) begin : g_shift
        assign shifted[k] = cur_stages[k+1];
    end
    assign shifted[STAGES-1] = feedback;

    assign nxt_stages = from_zero ? SEED_VAL : shifted;
endmodule

// File: rtl/lfsr4_wrap_detect.sv
module lfsr4_wrap_detect
    import lfsr4_pkg::*;
(
    input  stage_vec_t cur_stages,
    input  logic       step_taken,
    output logic       wrap_hit
);
    assign wrap_hit = step_taken && (cur_stages == LAST_VAL);
endmodule

// File: rtl/lfsr4_gen.sv
module lfsr4_gen
    import lfsr4_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       step_en,
    input  logic       load_en,
    input  logic [3:0] load_val,
    output logic       x1,
    output logic       x2,
    output logic       x3,
    output logic       x4,
    output logic       serial_out,
    output logic       wrap_pulse
);
    lfsr_reg_t  reg_d, reg_q;
    stage_vec_t step_val;
    logic       zero_seen;
    logic       step_taken;
    logic       wrap_hit;

    assign step_taken = step_en && !load_en;

    lfsr4_step u_step (
        .cur_stages (reg_q.stages),
        .nxt_stages (step_val),
        .from_zero  (zero_seen)
    );

    lfsr4_wrap_detect u_wrap (
        .cur_stages (reg_q.stages),
        .step_taken (step_taken),
        .wrap_hit   (wrap_hit)
    );

    always_comb begin
        reg_d      = reg_q;
        reg_d.wrap = 1'b0;
        if (rst) begin
            reg_d.stages = SEED_VAL;
        end else if (load_en) begin
            reg_d.stages = stage_vec_t'(load_val);
        end else if (step_en) begin
            reg_d.stages = step_val;
            reg_d.wrap   = wrap_hit && !zero_seen;
        end
    end

    always_ff @(posedge clk) begin
        reg_q <= reg_d;
    end

    assign x1         = reg_q.stages[3];
    assign x2         = reg_q.stages[2];
    assign x3         = reg_q.stages[1];
    assign x4         = reg_q.stages[0];
    assign serial_out = reg_q.stages[0];
    assign wrap_pulse = reg_q.wrap;

    // R1
    reset_seed_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (reg_q.stages == SEED_VAL && !wrap_pulse));

    // R4
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!step_en && !load_en) |=> ($stable(reg_q.stages) && !wrap_pulse));

    // R5
    load_chk: assert property (@(posedge clk) disable iff (rst)
        load_en |=> (reg_q.stages == $past(load_val) && !wrap_pulse));

    // R6
    recover_chk: assert property (@(posedge clk) disable iff (rst)
        (step_taken && reg_q.stages == ZERO_VAL) |=> (reg_q.stages == SEED_VAL && !wrap_pulse));

    // R2
    never_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (step_taken && reg_q.stages != ZERO_VAL) |=> (reg_q.stages != ZERO_VAL));

    // R7
    wrap_seed_chk: assert property (@(posedge clk) disable iff (rst)
        wrap_pulse |-> (reg_q.stages == SEED_VAL && $past(reg_q.stages) == LAST_VAL));

    // R7
    wrap_single_chk: assert property (@(posedge clk) disable iff (rst)
        wrap_pulse |=> !wrap_pulse);
endmodule

// File: tb/lfsr4_gen_bench.sv
module lfsr4_gen_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       step_en = 1'b0;
    logic       load_en = 1'b0;
    logic [3:0] load_val = 4'h0;
    logic       x1, x2, x3, x4, serial_out, wrap_pulse;

    int checks = 0;
    int bad = 0;
    logic [3:0] exp_st = 4'b1000;
    logic       exp_wr = 1'b0;

    always #4 clk = ~clk;

    lfsr4_gen u_lfsr4_gen (
        .clk(clk), .rst(rst), .step_en(step_en), .load_en(load_en),
        .load_val(load_val), .x1(x1), .x2(x2), .x3(x3), .x4(x4),
        .serial_out(serial_out), .wrap_pulse(wrap_pulse)
    );

    function automatic logic [4:0] model(logic r, logic l, logic [3:0] lv,
                                         logic s, logic [3:0] cur);
        if (r) return {1'b0, 4'b1000};
        if (l) return {1'b0, lv};
        if (!s) return {1'b0, cur};
        if (cur == 4'b0000) return {1'b0, 4'b1000};
        return {cur == 4'b0001, cur[1] ^ cur[0], cur[3:1]};
    endfunction

    function automatic logic [3:0] seq_at(int i);
        case (i % 15)
            0: return 4'b1000;  1: return 4'b0100;  2: return 4'b0010;
            3: return 4'b1001;  4: return 4'b1100;  5: return 4'b0110;
            6: return 4'b1011;  7: return 4'b0101;  8: return 4'b1010;
            9: return 4'b1101; 10: return 4'b1110; 11: return 4'b1111;
           12: return 4'b0111; 13: return 4'b0011;
           default: return 4'b0001;
        endcase
    endfunction

    task automatic chk(string tag, logic [4:0] act, logic [4:0] expv);
        checks++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s actual=%b expected=%b", tag, act, expv);
        end
    endtask

    task automatic cyc(string tag, logic r, logic l, logic [3:0] lv, logic s);
        logic [4:0] nx;
        @(negedge clk);
        rst = r; load_en = l; load_val = lv; step_en = s;
        nx = model(r, l, lv, s, exp_st);
        exp_st = nx[3:0]; exp_wr = nx[4];
        @(posedge clk); #1;
        chk(tag, {wrap_pulse, x1, x2, x3, x4}, {exp_wr, exp_st});
        chk("R8 serial", {4'b0, serial_out}, {4'b0, x4});
    endtask

    initial begin
        #(8 * 200000);
        bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        int dummy;
        dummy = $urandom(32'd20240611);
        // R1 reset state
        cyc("R1 reset", 1, 0, 4'h0, 0);
        cyc("R1 reset hold", 1, 0, 4'h5, 1);
        // R3 full period walk, R2 rule
        for (int i = 1; i <= 15; i++) begin
            cyc("R2 step", 0, 0, 4'h0, 1);
            chk("R3 order", {1'b0, x1, x2, x3, x4}, {1'b0, seq_at(i)});
        end
        chk("R7 wrap at period", {4'b0, wrap_pulse}, 5'd1);
        // R4 hold, wrap drops
        cyc("R4 hold", 0, 0, 4'h0, 0);
        chk("R4 wrap low", {4'b0, wrap_pulse}, 5'd0);
        cyc("R4 hold again", 0, 0, 4'hF, 0);
        // R6 zero recovery
        cyc("R5 load zero", 0, 1, 4'h0, 0);
        cyc("R6 recover", 0, 0, 4'h0, 1);
        chk("R6 seed no wrap", {wrap_pulse, x1, x2, x3, x4}, 5'b01000);
        // R7 wrap after loaded 0001
        cyc("R5 load last", 0, 1, 4'b0001, 1);
        cyc("R7 wrap step", 0, 0, 4'h0, 1);
        chk("R7 wrap set", {4'b0, wrap_pulse}, 5'd1);
        // R9 load beats step, reset beats load
        cyc("R9 load over step", 0, 1, 4'b1000, 1);
        chk("R9 no wrap on load", {4'b0, wrap_pulse}, 5'd0);
        cyc("R9 rst over load", 1, 1, 4'b0110, 1);
        chk("R9 seed", {1'b0, x1, x2, x3, x4}, 5'b01000);
        // random mix
        for (int n = 0; n < 3000; n++) begin
            logic r, l, s;
            logic [3:0] v;
            r = ($urandom % 50) == 0;
            l = ($urandom % 8) == 0;
            s = ($urandom % 2) == 0;
            v = ($urandom % 4 == 0) ? 4'h0 : (($urandom % 3 == 0) ? 4'h1 : 4'($urandom));
            cyc("R2 R5 R9 random", r, l, v, s);
        end
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule